// File: doc/BRIEF.md
# Microcoded 16-bit Datapath

This block is the execution half of a horizontally microprogrammed processor. Each clock cycle it receives one decoded microinstruction as a set of field inputs. It reads two operands out of a small register file. It routes either the left operand or the memory buffer into a four-function ALU, and passes the result through a one-bit shifter. It then writes the shifted value back to a register, to the memory buffer, or to both. The block drives the memory address and the write data to the memory. It also reports sign and zero flags to the external sequencer for conditional branching.

The register file has fixed roles. Entry 0 is the accumulator. Entry 1 is the program counter. Entry 2 holds the instruction. Entry 3 is scratch. Entry 4 holds a 13-bit address mask. Entry 5 is a read-only constant one. The ALU has no subtract function, so the microprogram builds `x - y` as `x + 1 + ~y`. The control store, the next-address logic and the memory itself sit outside this block.

Top module: `mcdp_top`

## Requirements
- R1: After reset, registers 0 to 3, the address register and the buffer register are zero. Register 4 reads 0x1FFF and register 5 reads 0x0001.
- R2: `aluFn` selects the ALU operation: 00 adds the two operands, 01 ANDs them bitwise, 10 passes the left operand unchanged, and 11 gives the one's complement of the left operand.
- R3: `shFn` selects the shift applied to the ALU result: 00 leaves it unchanged, 01 shifts it left by one with zero fill, 10 shifts it right by one (logical, zero fill), and 11 also leaves it unchanged.
- R4: When `selMbr` is 0 the left ALU operand is the register selected by `aSel`. When `selMbr` is 1 it is the current buffer register value.
- R5: `aSel` and `bSel` pick registers 0 to 5. The values 6 and 7 read as zero.
- R6: When `stReg` is 1, the shifter output is written at the clock edge into the register numbered by `cSel`. A write to register 5, 6 or 7 changes no register.
- R7: `flagN` is bit 15 of the unshifted ALU result and `flagZ` is 1 exactly when all 16 bits of that result are zero. Both flags are combinational in the same cycle.
- R8: When `ldMar` is 1, the address register loads bits 12:0 of the right operand at the clock edge. Otherwise it holds. `memAddr` always shows the address register.
- R9: When `ldMbr` is 1, the buffer register loads the shifter output at the clock edge. `memWdata` always shows the buffer register.
- R10: `memRdata` is captured into the buffer register only in the second of two consecutive `rdReq` cycles, counted in pairs from the first. If `ldMbr` is 1 in that cycle, the shifter output is loaded and the read data is dropped.
- R11: The three-step sequence ACC := ACC + 1, TMP := ~MBR, ACC := ACC + TMP leaves ACC = ACC − MBR modulo 2^16. The final add sets `flagZ` for equal values and `flagN` for a negative difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| selMbr | input | 1 | Left operand source: 0 register, 1 buffer register |
| aluFn | input | 2 | ALU operation select |
| shFn | input | 2 | Shifter operation select |
| ldMbr | input | 1 | Load shifter output into buffer register |
| ldMar | input | 1 | Load right operand low bits into address register |
| rdReq | input | 1 | Memory read cycle in progress |
| stReg | input | 1 | Write shifter output into a register |
| cSel | input | 3 | Destination register number |
| bSel | input | 3 | Right operand register number |
| aSel | input | 3 | Left operand register number |
| memRdata | input | 16 | Data returned by memory |
| memAddr | output | 13 | Memory address (address register) |
| memWdata | output | 16 | Memory write data (buffer register) |
| flagN | output | 1 | Sign of the ALU result |
| flagZ | output | 1 | ALU result is zero |

## Verification
Every ALU and shift code is run on operands chosen so that the outcomes differ: high and low bits are set, so AND differs from pass and a left shift differs from a right shift. Register contents are read out by passing them into the buffer register. This shows register writes, the ignored writes to 5 and 7, and the zero read of selectors 6 and 7 at `memWdata`. Read runs of one, two and three cycles, each with different data, show which cycle captures memory. A run with a same-cycle buffer load shows that the load wins. Subtraction is run with positive, zero and negative differences to show each flag combination.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 13;
  localparam int NREG      = 6;
  localparam int SEL_W     = 3;
  localparam int MASK_IDX  = 4;
  localparam int CONST_IDX = 5;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_AND  = 2'b01,
    ALU_PASS = 2'b10,
    ALU_NOT  = 2'b11
  } aluFn_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_SPARE = 2'b11
  } shFn_e;

  typedef struct packed {
    logic [NREG-1:0] regWe;
    logic            marLoad;
    logic            mbrLoad;
    logic            mbrCapture;
    logic            useMbr;
    aluFn_e          aluOp;
    shFn_e           shOp;
  } strobes_t;
endpackage

// File: rtl/mcdp_ctrl.sv
module mcdp_ctrl
  import mcdp_pkg::*;
#(
  parameter int NUM_REGS  = NREG,
  parameter int SEL_BITS  = SEL_W,
  parameter int CONST_REG = CONST_IDX
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selMbr,
  input  logic [1:0]          aluFn,
  input  logic [1:0]          shFn,
  input  logic                ldMbr,
  input  logic                ldMar,
  input  logic                rdReq,
  input  logic                stReg,
  input  logic [SEL_BITS-1:0] cSel,
  output strobes_t            strobes
);
  // Marks that the previous cycle was the first half of a read pair.
  logic rdPending;

  always_ff @(posedge clk) begin
    if (!rstN) rdPending <= 1'b0;
    else       rdPending <= rdReq & ~rdPending;
  end

  logic [NUM_REGS-1:0] weVec;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
    if (i == CONST_REG) begin : g_ro
      assign weVec[i] = 1'b0;
    end else begin : g_rw
      assign weVec[i] = stReg && (cSel == SEL_BITS'(i));
    end
  end

  always_comb begin
    strobes.regWe      = weVec;
    strobes.marLoad    = ldMar;
    strobes.mbrLoad    = ldMbr;
    strobes.mbrCapture = rdReq & rdPending & ~ldMbr;
    strobes.useMbr     = selMbr;
    strobes.aluOp      = aluFn_e'(aluFn);
    strobes.shOp       = shFn_e'(shFn);
  end
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
  import mcdp_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int AW        = ADDR_W,
  parameter int NUM_REGS  = NREG,
  parameter int SEL_BITS  = SEL_W,
  parameter int MASK_REG  = MASK_IDX,
  parameter int CONST_REG = CONST_IDX
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REGS-1:0] we,
  input  logic [DW-1:0]       wdata,
  input  logic [SEL_BITS-1:0] aSel,
  input  logic [SEL_BITS-1:0] bSel,
  output logic [DW-1:0]       opA,
  output logic [DW-1:0]       opB
);
  localparam logic [DW-1:0] MASK_INIT  = DW'((64'(1) << AW) - 64'(1));
  localparam logic [DW-1:0] CONST_INIT = DW'(1);

  logic [DW-1:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DW-1:0] INIT = (i == MASK_REG)  ? MASK_INIT :
                                     (i == CONST_REG) ? CONST_INIT : '0;
    always_ff @(posedge clk) begin
      if (!rstN)     regQ[i] <= INIT;
      else if (we[i]) regQ[i] <= wdata;
    end
  end

  always_comb begin
    opA = '0;
    opB = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (aSel == SEL_BITS'(i)) opA = regQ[i];
      if (bSel == SEL_BITS'(i)) opB = regQ[i];
    end
  end
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          useMbr,
  input  aluFn_e        aluOp,
  input  shFn_e         shOp,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] mbrQ,
  input  logic [DW-1:0] opB,
  output logic [DW-1:0] aluRes,
  output logic [DW-1:0] shOut,
  output logic          flagN,
  output logic          flagZ
);
  logic [DW-1:0] leftIn;

  assign leftIn = useMbr ? mbrQ : opA;

  always_comb begin
    unique case (aluOp)
      ALU_ADD:  aluRes = leftIn + opB;
      ALU_AND:  aluRes = leftIn & opB;
      ALU_PASS: aluRes = leftIn;
      default:  aluRes = ~leftIn;
    endcase
  end

  always_comb begin
    unique case (shOp)
      SH_LEFT:  shOut = {aluRes[DW-2:0], 1'b0};
      SH_RIGHT: shOut = {1'b0, aluRes[DW-1:1]};
      default:  shOut = aluRes;
    endcase
  end

  assign flagN = aluRes[DW-1];
  assign flagZ = (aluRes == '0);
endmodule

// File: rtl/mcdp_memregs.sv
module mcdp_memregs
  import mcdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          marLoad,
  input  logic          mbrLoad,
  input  logic          mbrCapture,
  input  logic [AW-1:0] addrIn,
  input  logic [DW-1:0] shOut,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] marQ,
  output logic [DW-1:0] mbrQ
);
  always_ff @(posedge clk) begin
    if (!rstN)        marQ <= '0;
    else if (marLoad) marQ <= addrIn;
  end

  // A microinstruction load takes priority over the memory capture.
  always_ff @(posedge clk) begin
    if (!rstN)           mbrQ <= '0;
    else if (mbrLoad)    mbrQ <= shOut;
    else if (mbrCapture) mbrQ <= memRdata;
  end
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
  import mcdp_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int AW       = ADDR_W,
  parameter int SEL_BITS = SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selMbr,
  input  logic [1:0]          aluFn,
  input  logic [1:0]          shFn,
  input  logic                ldMbr,
  input  logic                ldMar,
  input  logic                rdReq,
  input  logic                stReg,
  input  logic [SEL_BITS-1:0] cSel,
  input  logic [SEL_BITS-1:0] bSel,
  input  logic [SEL_BITS-1:0] aSel,
  input  logic [DW-1:0]       memRdata,
  output logic [AW-1:0]       memAddr,
  output logic [DW-1:0]       memWdata,
  output logic                flagN,
  output logic                flagZ
);
  strobes_t      strobes;
  logic [DW-1:0] opA, opB, aluRes, shOut, mbrQ;

  mcdp_ctrl #(.SEL_BITS(SEL_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .selMbr(selMbr), .aluFn(aluFn), .shFn(shFn),
    .ldMbr(ldMbr), .ldMar(ldMar), .rdReq(rdReq), .stReg(stReg),
    .cSel(cSel), .strobes(strobes)
  );

  mcdp_regfile #(.DW(DW), .AW(AW), .SEL_BITS(SEL_BITS)) u_regs (
    .clk(clk), .rstN(rstN), .we(strobes.regWe), .wdata(shOut),
    .aSel(aSel), .bSel(bSel), .opA(opA), .opB(opB)
  );

  mcdp_alu #(.DW(DW)) u_alu (
    .useMbr(strobes.useMbr), .aluOp(strobes.aluOp), .shOp(strobes.shOp),
    .opA(opA), .mbrQ(mbrQ), .opB(opB), .aluRes(aluRes), .shOut(shOut),
    .flagN(flagN), .flagZ(flagZ)
  );

  mcdp_memregs #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rstN(rstN), .marLoad(strobes.marLoad),
    .mbrLoad(strobes.mbrLoad), .mbrCapture(strobes.mbrCapture),
    .addrIn(opB[AW-1:0]), .shOut(shOut), .memRdata(memRdata),
    .marQ(memAddr), .mbrQ(mbrQ)
  );

  assign memWdata = mbrQ;
endmodule

// File: rtl/mcdp_checker.sv
module mcdp_checker #(
  parameter int DW = 16,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rstN,
  input logic          selMbr,
  input logic [1:0]    aluFn,
  input logic          ldMbr,
  input logic          ldMar,
  input logic          rdReq,
  input logic [2:0]    aSel,
  input logic [DW-1:0] opB,
  input logic [DW-1:0] aluRes,
  input logic [DW-1:0] shOut,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          flagN,
  input logic          flagZ
);
  // R8
  mar_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldMar |=> memAddr == $past(opB[AW-1:0]));

  // R8
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldMar |=> $stable(memAddr));

  // R9
  mbr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldMbr |=> memWdata == $past(shOut));

  // R10
  mbr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ldMbr && !rdReq) |=> $stable(memWdata));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flagN && flagZ));

  // R1
  const_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aSel == 3'd5 && !selMbr && aluFn == 2'b10) |-> aluRes == DW'(1));

  // R5
  sel_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aSel >= 3'd6 && !selMbr && aluFn == 2'b10) |-> flagZ);
endmodule

bind mcdp_top mcdp_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .selMbr(selMbr), .aluFn(aluFn), .ldMbr(ldMbr),
  .ldMar(ldMar), .rdReq(rdReq), .aSel(aSel), .opB(opB), .aluRes(aluRes),
  .shOut(shOut), .memAddr(memAddr), .memWdata(memWdata),
  .flagN(flagN), .flagZ(flagZ)
);

// File: tb/tb_mcdp_top.sv
module tb_mcdp_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selMbr = 1'b0;
  logic [1:0]  aluFn = 2'b00;
  logic [1:0]  shFn = 2'b00;
  logic        ldMbr = 1'b0;
  logic        ldMar = 1'b0;
  logic        rdReq = 1'b0;
  logic        stReg = 1'b0;
  logic [2:0]  cSel = 3'd0;
  logic [2:0]  bSel = 3'd0;
  logic [2:0]  aSel = 3'd0;
  logic [15:0] memRdata = 16'h0;
  logic [12:0] memAddr;
  logic [15:0] memWdata;
  logic        flagN, flagZ;

  mcdp_top dut (
    .clk(clk), .rstN(rstN), .selMbr(selMbr), .aluFn(aluFn), .shFn(shFn),
    .ldMbr(ldMbr), .ldMar(ldMar), .rdReq(rdReq), .stReg(stReg),
    .cSel(cSel), .bSel(bSel), .aSel(aSel), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .flagN(flagN), .flagZ(flagZ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [12:0] expAddr;
    logic [15:0] expData;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;

  // Reference state built from the requirements.
  logic [15:0] mdl [6];
  logic [15:0] mdlMbr;
  logic [12:0] mdlMar;
  bit          mdlArmed;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [2:0] s);
    return (s < 3'd6) ? mdl[s] : 16'h0;
  endfunction

  task automatic step(input logic mx, input logic [1:0] fn, input logic [1:0] sh,
                      input logic lm, input logic la, input logic rq, input logic st,
                      input logic [2:0] c, input logic [2:0] b, input logic [2:0] a,
                      input logic [15:0] rdat, input string tag);
    logic [15:0] left, res, sv;
    item_t it;
    @(negedge clk);
    selMbr = mx; aluFn = fn; shFn = sh; ldMbr = lm; ldMar = la; rdReq = rq;
    stReg = st; cSel = c; bSel = b; aSel = a; memRdata = rdat;
    #1;
    left = mx ? mdlMbr : rd(a);
    case (fn)
      2'b00: res = left + rd(b);
      2'b01: res = left & rd(b);
      2'b10: res = left;
      default: res = ~left;
    endcase
    case (sh)
      2'b01: sv = {res[14:0], 1'b0};
      2'b10: sv = {1'b0, res[15:1]};
      default: sv = res;
    endcase
    check({tag, " R7 N"}, {15'h0, flagN}, {15'h0, res[15]});
    check({tag, " R7 Z"}, {15'h0, flagZ}, {15'h0, res == 16'h0});
    if (la) mdlMar = rd(b)[12:0];
    if (lm) mdlMbr = sv;
    else if (rq && mdlArmed) mdlMbr = rdat;
    mdlArmed = rq && !mdlArmed;
    if (st && c < 3'd5) mdl[c] = sv;
    it.tag = tag; it.expAddr = mdlMar; it.expData = mdlMbr;
    sbq.push_back(it);
  endtask

  // Shorthands built on step.
  task automatic peek(input logic [2:0] r, input string tag);
    step(1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, r, 16'h0, tag);
  endtask

  task automatic setReg(input logic [2:0] r, input logic [15:0] v, input string tag);
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 16'hBAD0, tag);
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, v, tag);
    step(1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, r, 3'd0, 3'd0, 16'h0, tag);
  endtask

  task automatic alu(input logic [1:0] fn, input logic [1:0] sh, input logic [2:0] c,
                     input logic [2:0] b, input logic [2:0] a, input string tag);
    step(1'b0, fn, sh, 1'b1, 1'b0, 1'b0, 1'b1, c, b, a, 16'h0, tag);
  endtask

  task automatic subtract(input logic [15:0] x, input logic [15:0] y, input string tag);
    setReg(3'd0, x, tag);
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 16'h0, tag);
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, y, tag);
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd5, 3'd0, 16'h0, tag);
    step(1'b1, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 3'd0, 3'd0, 16'h0, tag);
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd3, 3'd0, 16'h0, tag);
    peek(3'd0, tag);
    check({tag, " difference"}, mdl[0], x - y);
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check({it.tag, " addr"}, {3'b0, memAddr}, {3'b0, it.expAddr});
        check({it.tag, " data"}, memWdata, it.expData);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 6; i++) mdl[i] = 16'h0;
    mdl[4] = 16'h1FFF; mdl[5] = 16'h0001;
    mdlMbr = 16'h0; mdlMar = 13'h0; mdlArmed = 0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state of address and buffer
    check("R1 reset addr", {3'b0, memAddr}, 16'h0);
    check("R1 reset data", memWdata, 16'h0);
    peek(3'd4, "R1 mask reg");
    peek(3'd5, "R1 const reg");
    peek(3'd0, "R1 acc");
    peek(3'd3, "R1 tmp");

    // R10 read pair captures on second cycle only
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 16'hDEAD, "R10 first");
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 16'h1234, "R10 second");
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 16'h5555, "R10 third");
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 16'h7777, "R10 idle");
    // R4 left operand from buffer
    step(1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 3'd0, 16'h0, "R4 mbr to acc");
    peek(3'd0, "R4 acc");
    // R2 add
    alu(2'b00, 2'b00, 3'd0, 3'd5, 3'd0, "R2 add");
    // R2 and, pass, complement
    setReg(3'd0, 16'hF00F, "R2 load");
    alu(2'b01, 2'b00, 3'd3, 3'd4, 3'd0, "R2 and");
    alu(2'b10, 2'b00, 3'd2, 3'd0, 3'd0, "R2 pass");
    alu(2'b11, 2'b00, 3'd1, 3'd4, 3'd0, "R2 complement");
    peek(3'd1, "R6 pc");
    // R3 shifts and R7 sign
    setReg(3'd0, 16'h8001, "R3 load");
    alu(2'b10, 2'b01, 3'd3, 3'd0, 3'd0, "R3 left");
    alu(2'b10, 2'b10, 3'd3, 3'd0, 3'd0, "R3 right");
    alu(2'b10, 2'b11, 3'd3, 3'd0, 3'd0, "R3 spare");
    alu(2'b00, 2'b01, 3'd3, 3'd0, 3'd0, "R3 add then left");
    // R6 ignored writes
    alu(2'b11, 2'b00, 3'd5, 3'd4, 3'd5, "R6 write r5");
    peek(3'd5, "R6 r5 kept");
    alu(2'b10, 2'b00, 3'd7, 3'd0, 3'd4, "R6 write r7");
    for (int r = 0; r < 5; r++) peek(3'(r), "R6 regs kept");
    // R5 out-of-range selectors
    peek(3'd6, "R5 a6");
    alu(2'b00, 2'b00, 3'd3, 3'd7, 3'd5, "R5 b7");
    // R8 address register
    setReg(3'd2, 16'hE123, "R8 load ir");
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd2, 3'd0, 16'h0, "R8 mar load");
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd4, 3'd0, 16'h0, "R8 mar hold");
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd4, 3'd0, 16'h0, "R8 mar mask");
    // R9 and R10 override
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd0, 16'hAAAA, "R10 ovr first");
    step(1'b0, 2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 3'd5, 16'hCCCC, "R9 R10 override");
    // R11 subtraction
    subtract(16'h0010, 16'h0003, "R11 positive");
    subtract(16'h0042, 16'h0042, "R11 zero");
    subtract(16'h0003, 16'h0010, "R11 negative");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule